// File: doc/BRIEF.md
# Configurable Registered Buffer with Delayed Parity Check

This block is a registered data buffer that captures an input bus on the rising clock edge and presents it on a registered output bus. It has two modes. In the wide mode, each of 25 data inputs feeds exactly one output bit. In the split mode, a 14-bit slice of the inputs is copied to two 14-bit output banks. A mapping select input chooses whether that slice is taken from the low or the high end of the input bus. The inputs outside the chosen slice are ignored.

Two active-low chip-select inputs gate the capture. When both are high, the outputs keep their value. When either one is low, the outputs follow the inputs. An asynchronous active-low reset clears every register at once and overrides the gating.

A parity checker compares a parity bit against the word that was registered on the previous edge. The parity bit arrives one cycle after its data. The checker reports the result in two ways: a registered partial-parity output, and an active-low error flag that stays low for two cycles after a mismatch.

Top module: `regbuf_par`

## Requirements
- R1: When `split_mode` is 0, each rising edge with capture enabled loads `d_in[24:0]` into `q_out[24:0]`, and `q_out[27:25]` is 0.
- R2: When `split_mode` is 1 and `map_high` is 0, a capture loads `d_in[13:0]` into both `q_out[13:0]` and `q_out[27:14]`. `d_in[24:14]` has no effect.
- R3: When `split_mode` is 1 and `map_high` is 1, a capture loads `d_in[24:11]` into both `q_out[13:0]` and `q_out[27:14]`. `d_in[10:0]` has no effect.
- R4: Capture is enabled unless `cs0_n` and `cs1_n` are both 1 at the edge. When both are 1, `q_out` keeps its value.
- R5: While `rst_n` is 0, `q_out`, `ppo_out` and `qerr_n` are forced to 0, 0 and 1. This happens immediately, without waiting for a clock edge, and it applies regardless of the chip-select inputs.
- R6: At each edge, `ppo_out` is loaded with the XOR of `par_in` and the checked bits of the registered word as it stood before that edge. The checked bits are `q_out[24:0]` in wide mode and `q_out[13:0]` in split mode. The parity is even, so 1 means an error.
- R7: When the value loaded into `ppo_out` is 1, `qerr_n` is 0 for exactly the next two cycles, unless a further error or reset intervenes.
- R8: A new error while `qerr_n` is already 0 restarts the two-cycle hold from that edge.
- R9: Asserting `rst_n` low while `qerr_n` is 0 returns `qerr_n` to 1 at once.
- R10: After reset is released with `d_in` held at 0, `q_out` stays 0 on every following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_mode | input | 1 | 0: 25-bit one-to-one, 1: 14-bit one-to-two |
| map_high | input | 1 | Split-mode slice select: 0 low slice, 1 high slice |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| d_in | input | 25 | Data inputs |
| par_in | input | 1 | Parity bit for the word captured one edge earlier |
| q_out | output | 28 | Registered outputs; two 14-bit banks in split mode |
| ppo_out | output | 1 | Registered partial parity (1 = mismatch) |
| qerr_n | output | 1 | Error flag, active low, held two cycles |

## Verification
Chip-select gating and the parity check can act on the same edge. On a gated edge the word does not change, so the parity bit presented at the next edge must be judged against the held word and not against the new inputs. The bench creates this case with directed sequences and random ones. It freezes the outputs and keeps changing `d_in`, then computes the expected parity from its own record of the held word. It checks `ppo_out` and `qerr_n` against that record, so a checker that used the live inputs or dropped the hold would show a mismatch.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    localparam int WIDE_BITS    = 25;
    localparam int NARROW_BITS  = 14;
    localparam int OUT_BITS     = 2 * NARROW_BITS;
    localparam int ERR_HOLD_CYC = 2;
    localparam int HOLD_CNT_W   = $clog2(ERR_HOLD_CYC + 1);

    typedef enum logic {
        MODE_WIDE  = 1'b0,
        MODE_SPLIT = 1'b1
    } buf_mode_e;

    typedef enum logic {
        SLICE_LOW  = 1'b0,
        SLICE_HIGH = 1'b1
    } slice_sel_e;

    typedef struct packed {
        logic                  ppo;
        logic [HOLD_CNT_W-1:0] left;
    } chk_state_t;

endpackage

// File: rtl/regbuf_capture.sv
module regbuf_capture
    import regbuf_pkg::*;
#(
    parameter int WIDE   = WIDE_BITS,
    parameter int NARROW = NARROW_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  buf_mode_e             mode,
    input  slice_sel_e            slice,
    input  logic                  hold,
    input  logic [WIDE-1:0]       d,
    output logic [2*NARROW-1:0]   q
);
    localparam int OUT_W  = 2 * NARROW;
    localparam int B_BASE = WIDE - NARROW;

    logic [OUT_W-1:0] next_word;

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        localparam int LANE  = i % NARROW;
        localparam int SRC_B = B_BASE + LANE;
        logic split_bit;
        assign split_bit = (slice == SLICE_HIGH) ? d[SRC_B] : d[LANE];
        if (i < WIDE) begin : g_in
            assign next_word[i] = (mode == MODE_WIDE) ? d[i] : split_bit;
        end else begin : g_pad
            assign next_word[i] = (mode == MODE_WIDE) ? 1'b0 : split_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!hold) begin
            q <= next_word;
        end
    end

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity
    import regbuf_pkg::*;
#(
    parameter int WIDE     = WIDE_BITS,
    parameter int NARROW   = NARROW_BITS,
    parameter int HOLD_CYC = ERR_HOLD_CYC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  buf_mode_e       mode,
    input  logic [WIDE-1:0] word,
    input  logic            par_in,
    output logic            ppo,
    output logic            err_n
);
    chk_state_t st;
    logic       word_sum;
    logic       mismatch;

    always_comb begin
        word_sum = (mode == MODE_WIDE) ? ^word : ^word[NARROW-1:0];
        mismatch = word_sum ^ par_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st.ppo <= mismatch;
            if (mismatch) begin
                st.left <= HOLD_CNT_W'(HOLD_CYC);
            end else if (st.left != '0) begin
                st.left <= st.left - HOLD_CNT_W'(1);
            end
        end
    end

    assign ppo   = st.ppo;
    assign err_n = (st.left == '0);

endmodule

// File: rtl/regbuf_par.sv
module regbuf_par
    import regbuf_pkg::*;
#(
    parameter int WIDE   = WIDE_BITS,
    parameter int NARROW = NARROW_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                split_mode,
    input  logic                map_high,
    input  logic                cs0_n,
    input  logic                cs1_n,
    input  logic [WIDE-1:0]     d_in,
    input  logic                par_in,
    output logic [2*NARROW-1:0] q_out,
    output logic                ppo_out,
    output logic                qerr_n
);
    buf_mode_e  mode;
    slice_sel_e slice;
    logic       hold;

    assign mode  = buf_mode_e'(split_mode);
    assign slice = slice_sel_e'(map_high);
    assign hold  = cs0_n & cs1_n;

    regbuf_capture #(.WIDE(WIDE), .NARROW(NARROW)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .slice (slice),
        .hold  (hold),
        .d     (d_in),
        .q     (q_out)
    );

    regbuf_parity #(.WIDE(WIDE), .NARROW(NARROW), .HOLD_CYC(ERR_HOLD_CYC)) u_parity (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .word   (q_out[WIDE-1:0]),
        .par_in (par_in),
        .ppo    (ppo_out),
        .err_n  (qerr_n)
    );

endmodule

// File: rtl/regbuf_par_chk.sv
module regbuf_par_chk
    import regbuf_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                split_mode,
    input logic                cs0_n,
    input logic                cs1_n,
    input logic                par_in,
    input logic [OUT_BITS-1:0] q_out,
    input logic                ppo_out,
    input logic                qerr_n
);
    logic seen_bad;
    assign seen_bad = par_in ^ (split_mode ? ^q_out[NARROW_BITS-1:0]
                                           : ^q_out[WIDE_BITS-1:0]);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && !ppo_out && qerr_n)); // R5

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> $stable(q_out)); // R4

    AST_BANKS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (split_mode && !(cs0_n && cs1_n))
        |=> (q_out[NARROW_BITS-1:0] == q_out[OUT_BITS-1:NARROW_BITS])); // R2

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_bad |=> (ppo_out && !qerr_n)); // R6

    AST_ERR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qerr_n) |=> !qerr_n); // R7

endmodule

bind regbuf_par regbuf_par_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_mode (split_mode),
    .cs0_n      (cs0_n),
    .cs1_n      (cs1_n),
    .par_in     (par_in),
    .q_out      (q_out),
    .ppo_out    (ppo_out),
    .qerr_n     (qerr_n)
);

// File: tb/regbuf_par_bench.sv
module regbuf_par_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_mode = 1'b0;
    logic        map_high = 1'b0;
    logic        cs0_n = 1'b0;
    logic        cs1_n = 1'b0;
    logic [24:0] d_in = '0;
    logic        par_in = 1'b0;
    logic [27:0] q_out;
    logic        ppo_out;
    logic        qerr_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [27:0] exp_q;
    logic        exp_ppo;
    int          exp_left;

    always #5 clk = ~clk;

    regbuf_par u_regbuf_par (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .map_high(map_high),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .d_in(d_in), .par_in(par_in),
        .q_out(q_out), .ppo_out(ppo_out), .qerr_n(qerr_n)
    );

    function automatic logic [27:0] map_exp(logic sm, logic mh, logic [24:0] d);
        logic [13:0] sl;
        if (!sm) return {3'b000, d};
        sl = mh ? d[24:11] : d[13:0];
        return {sl, sl};
    endfunction

    function automatic logic par_exp(logic sm, logic [27:0] q);
        return sm ? ^q[13:0] : ^q[24:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0; exp_ppo <= 1'b0; exp_left <= 0;
        end else begin
            logic bad;
            bad = par_exp(split_mode, exp_q) ^ par_in;
            exp_ppo  <= bad;
            exp_left <= bad ? 2 : (exp_left > 0 ? exp_left - 1 : 0);
            if (!(cs0_n && cs1_n)) exp_q <= map_exp(split_mode, map_high, d_in);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " q_out"}, {4'b0, q_out}, {4'b0, exp_q});
        check({tag, " ppo_out"}, {31'b0, ppo_out}, {31'b0, exp_ppo});
        check({tag, " qerr_n"}, {31'b0, qerr_n}, {31'b0, exp_left == 0});
    endtask

    // Drive at negedge, take one edge, return at the next negedge.
    task automatic cycle(input logic sm, input logic mh, input logic c0, input logic c1,
                         input logic [24:0] d, input logic inject);
        split_mode = sm; map_high = mh; cs0_n = c0; cs1_n = c1; d_in = d;
        par_in = par_exp(sm, exp_q) ^ inject;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [27:0] held;
        void'($urandom(32'd20240607));
        repeat (2) @(negedge clk);
        check("R5 reset q_out", {4'b0, q_out}, 32'h0);
        check("R5 reset qerr_n", {31'b0, qerr_n}, 32'h1);
        check("R5 reset ppo_out", {31'b0, ppo_out}, 32'h0);

        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b0, 1'b0, 1'b0, 25'h0, 1'b0);
            check("R10 low after release", {4'b0, q_out}, 32'h0);
        end

        cycle(1'b0, 1'b0, 1'b0, 1'b1, 25'h1A5_5A5A, 1'b0);
        check("R1 wide load", {4'b0, q_out}, {7'b0, 25'h1A5_5A5A});
        check_all("R1");

        cycle(1'b1, 1'b0, 1'b1, 1'b0, 25'h1FF_C123, 1'b0);
        check("R2 low slice", {4'b0, q_out}, {4'b0, 14'h0123, 14'h0123});
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0123, 1'b0);
        check("R2 upper ignored", {4'b0, q_out}, {4'b0, 14'h0123, 14'h0123});

        cycle(1'b1, 1'b1, 1'b0, 1'b0, 25'h1AB_C7FF, 1'b0);
        check("R3 high slice", {4'b0, q_out}, {4'b0, 25'h1AB_C7FF >> 11, 14'(25'h1AB_C7FF >> 11)});
        check_all("R3");

        held = q_out;
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 25'h0F0_F0F0, 1'b0);
        check("R4 both high holds", {4'b0, q_out}, {4'b0, held});
        check_all("R4 gated parity");
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 25'h155_5555, 1'b0);
        check("R4 still held", {4'b0, q_out}, {4'b0, held});
        check_all("R4 gated parity wide");
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 25'h155_5555, 1'b0);
        check("R4 one low updates", {4'b0, q_out}, {7'b0, 25'h155_5555});

        cycle(1'b0, 1'b0, 1'b0, 1'b0, 25'h000_0007, 1'b1);
        check("R6 ppo on mismatch", {31'b0, ppo_out}, 32'h1);
        check("R7 flag low cycle 1", {31'b0, qerr_n}, 32'h0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 25'h000_0003, 1'b0);
        check("R6 ppo clear", {31'b0, ppo_out}, 32'h0);
        check("R7 flag low cycle 2", {31'b0, qerr_n}, 32'h0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 25'h000_0001, 1'b0);
        check("R7 flag released", {31'b0, qerr_n}, 32'h1);

        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0011, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0012, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0013, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0014, 1'b0);
        check("R8 hold restarted", {31'b0, qerr_n}, 32'h0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 25'h000_0015, 1'b0);
        check("R8 released after restart", {31'b0, qerr_n}, 32'h1);

        cycle(1'b0, 1'b0, 1'b1, 1'b1, 25'h1FF_FFFF, 1'b1);
        check("R9 flag low before reset", {31'b0, qerr_n}, 32'h0);
        #2 rst_n = 1'b0;
        #1;
        check("R9 flag high at once", {31'b0, qerr_n}, 32'h1);
        check("R5 async clear with cs high", {4'b0, q_out}, 32'h0);
        @(negedge clk);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 25'h1FF_FFFF, 1'b0);
        check("R5 reset beats gating", {4'b0, q_out}, 32'h0);
        d_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 25'h0, 1'b0);
        check("R10 low after second release", {4'b0, q_out}, 32'h0);

        for (int n = 0; n < 600; n++) begin
            logic sm, mh, c0, c1, inj;
            sm  = 1'($urandom_range(0, 1));
            mh  = 1'($urandom_range(0, 1));
            c0  = ($urandom_range(0, 3) != 0);
            c1  = ($urandom_range(0, 1) != 0);
            inj = ($urandom_range(0, 7) == 0);
            cycle(sm, mh, c0, c1, 25'($urandom), inj);
            if (c0 && c1)      check_all("R4 random");
            else if (!sm)      check_all("R1 random");
            else if (!mh)      check_all("R2 random");
            else               check_all("R3 random");
        end
        check_all("R6 R7 R8 final");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule